// File: doc/BRIEF.md
# Oversampled SPI Variable-Length Frame Receiver

This block receives one serial frame at a time from a three-wire link: a bit clock, an active-low select and a data line. It does not run on the bit clock. All three wires are resampled by a free-running system clock that is much faster than the bit clock. Edges of the bit clock and of the select are found by comparing each resampled wire with a copy of itself delayed by one cycle.

While the select is low, each rising edge of the bit clock shifts one data bit into a shift register and adds one to a bit counter. When the select returns high, the block publishes the captured bits as a parallel word, together with the number of bits received. A valid strobe one system cycle long marks the new word. The frame length can be anything from zero to the configured maximum (75 bits by default). If a frame runs longer than that, the extra bits are dropped and an overflow flag is raised with the word.

Top module: `spi_frame_rx`

## Requirements
- R1: Each of the three serial inputs passes through a 3-stage resynchroniser. When the select input goes high while it was low, `frm_valid` is high during the 4th system-clock cycle after the first rising edge that samples the new level.
- R2: A data bit is taken only on a rising edge of the bit clock seen while the resynchronised select is low. Bit-clock edges while the select is high change neither the outputs nor the next frame's contents or count.
- R3: Bits enter at bit 0 and move toward the top. In `frm_word`, the last bit received is at bit 0 and the first bit received is at bit `frm_bits`-1. All bits at positions `frm_bits` and above are 0.
- R4: `frm_bits` equals the number of bit-clock rising edges in the frame, from 0 up to FRAME_MAX (75).
- R5: `frm_valid` is high for exactly one system-clock cycle per frame, triggered only by the low-to-high change of the select.
- R6: If a frame has more than FRAME_MAX bit-clock edges, `frm_bits` saturates at FRAME_MAX, `frm_word` holds the first FRAME_MAX bits received, and `frm_ovf` is 1. `frm_ovf` is 0 after any frame that did not overflow.
- R7: `frm_word`, `frm_bits` and `frm_ovf` keep their values in every cycle where `frm_valid` is low.
- R8: The high-to-low change of the select clears the shift register, the counter and the overflow state, so no bit of an earlier frame shows in a later one.
- R9: A synchronous active-high reset clears all outputs to 0. The resynchronisers reset to the idle levels (bit clock low, select high, data low), so no strobe follows reset while the select stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial bit clock (asynchronous) |
| spi_sel_n | input | 1 | Active-low frame select (asynchronous) |
| spi_sdi | input | 1 | Serial data (asynchronous) |
| frm_word | output | FRAME_MAX | Captured frame, last bit at bit 0 |
| frm_bits | output | $clog2(FRAME_MAX+1) | Number of bits in the frame |
| frm_ovf | output | 1 | Frame exceeded FRAME_MAX bits |
| frm_valid | output | 1 | One-cycle strobe marking a new frame |

## Verification
The bench sends frames of 0, 1 and FRAME_MAX bits, then 80 bits. A receiver that counted past the limit, or kept the last bits instead of the first, would give a wrong count or a shifted word. A long frame followed by a short one shows whether the clear at frame start works; if it does not, stale upper bits appear above the new count. Bit-clock pulses are sent while the select is high; an unqualified capture would raise the count of the next frame. The bench also checks the strobe's exact cycle and width, and checks that reset in the middle of a frame gives no spurious strobe, which would happen if the select resynchroniser reset to low.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;
    localparam int SYNC_DEPTH = 3;
    localparam int LANES      = 3;
    localparam int LANE_SCK   = 0;
    localparam int LANE_SEL   = 1;
    localparam int LANE_SDI   = 2;
    // idle level of each lane after reset: sck low, select high, data low
    localparam logic [LANES-1:0] LANE_IDLE = 3'b010;
endpackage

// File: rtl/spi_rx_sync.sv
module spi_rx_sync #(
    parameter int   DEPTH   = 3,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[DEPTH-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {DEPTH{RST_VAL}};
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/spi_rx_edge.sv
module spi_rx_edge #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = level;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= prev_d;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/spi_rx_core.sv
module spi_rx_core #(
    parameter int FRAME_MAX = 75,
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck_rise,
    input  logic                 sel_rise,
    input  logic                 sel_fall,
    input  logic                 sel_lvl,
    input  logic                 sdi_lvl,
    output logic [FRAME_MAX-1:0] word,
    output logic [CNT_W-1:0]     bits,
    output logic                 ovf,
    output logic                 valid
);
    localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(FRAME_MAX);

    typedef struct packed {
        logic [FRAME_MAX-1:0] shreg;
        logic [CNT_W-1:0]     cnt;
        logic                 over;
        logic [FRAME_MAX-1:0] word;
        logic [CNT_W-1:0]     bits;
        logic                 ovf;
        logic                 valid;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (sel_fall) begin
            st_d.shreg = '0;
            st_d.cnt   = '0;
            st_d.over  = 1'b0;
        end
        if (sck_rise && !sel_lvl) begin
            if (st_d.cnt < CNT_LIMIT) begin
                st_d.shreg = {st_d.shreg[FRAME_MAX-2:0], sdi_lvl};
                st_d.cnt   = st_d.cnt + 1'b1;
            end else begin
                st_d.over  = 1'b1;
            end
        end
        if (sel_rise) begin
            st_d.word  = st_d.shreg;
            st_d.bits  = st_d.cnt;
            st_d.ovf   = st_d.over;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign word  = st_q.word;
    assign bits  = st_q.bits;
    assign ovf   = st_q.ovf;
    assign valid = st_q.valid;
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int FRAME_MAX = 75,
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 spi_sck,
    input  logic                 spi_sel_n,
    input  logic                 spi_sdi,
    output logic [FRAME_MAX-1:0] frm_word,
    output logic [CNT_W-1:0]     frm_bits,
    output logic                 frm_ovf,
    output logic                 frm_valid
);
    import spi_rx_pkg::*;

    logic [LANES-1:0] raw_in, sync_lvl;
    logic [1:0]       ev_rise, ev_fall;

    assign raw_in[LANE_SCK] = spi_sck;
    assign raw_in[LANE_SEL] = spi_sel_n;
    assign raw_in[LANE_SDI] = spi_sdi;

    for (genvar g = 0; g < LANES; g++) begin : g_sync
        spi_rx_sync #(.DEPTH(SYNC_DEPTH), .RST_VAL(LANE_IDLE[g])) u_sync (
            .clk(clk), .rst(rst), .din(raw_in[g]), .dout(sync_lvl[g])
        );
    end

    // edge lanes 0 (bit clock) and 1 (select) share lane indices with sync
    for (genvar e = 0; e < 2; e++) begin : g_edge
        spi_rx_edge #(.RST_VAL(LANE_IDLE[e])) u_edge (
            .clk(clk), .rst(rst), .level(sync_lvl[e]),
            .rise(ev_rise[e]), .fall(ev_fall[e])
        );
    end

    spi_rx_core #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst),
        .sck_rise(ev_rise[LANE_SCK]),
        .sel_rise(ev_rise[LANE_SEL]),
        .sel_fall(ev_fall[LANE_SEL]),
        .sel_lvl(sync_lvl[LANE_SEL]),
        .sdi_lvl(sync_lvl[LANE_SDI]),
        .word(frm_word), .bits(frm_bits), .ovf(frm_ovf), .valid(frm_valid)
    );

    logic unused_ok;
    assign unused_ok = ev_fall[LANE_SCK];
endmodule

// File: rtl/spi_frame_rx_chk.sv
module spi_frame_rx_chk #(
    parameter int FRAME_MAX = 75,
    parameter int CNT_W     = $clog2(FRAME_MAX + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [FRAME_MAX-1:0] frm_word,
    input logic [CNT_W-1:0]     frm_bits,
    input logic                 frm_ovf,
    input logic                 frm_valid
);
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> !frm_valid);

    // R4
    bits_range_chk: assert property (@(posedge clk) disable iff (rst)
        frm_bits <= CNT_W'(FRAME_MAX));

    // R6
    ovf_sat_chk: assert property (@(posedge clk) disable iff (rst)
        frm_ovf |-> (frm_bits == CNT_W'(FRAME_MAX)));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (frm_word >> frm_bits) == '0);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |-> ($stable(frm_word) && $stable(frm_bits) && $stable(frm_ovf)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (frm_bits == '0 && frm_word == '0 && !frm_ovf && !frm_valid));
endmodule

bind spi_frame_rx spi_frame_rx_chk #(.FRAME_MAX(FRAME_MAX), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .frm_word(frm_word), .frm_bits(frm_bits),
    .frm_ovf(frm_ovf), .frm_valid(frm_valid)
);

// File: tb/sim_spi_frame_rx.sv
`timescale 1ns/1ps
module sim_spi_frame_rx;
    localparam int FMAX = 75;
    localparam int CW   = $clog2(FMAX + 1);
    localparam int NV   = 6;
    localparam int VLEN [NV] = '{1, 8, 50, 13, 75, 0};
    localparam logic [79:0] VPAY [NV] = '{
        80'h1, 80'hA7, 80'h2_3456_789A_BCDE, 80'h1A5B,
        80'h5AB_CDEF_0123_4567_89AB, 80'h0};

    logic clk = 0, rst = 1;
    logic sck = 0, sel_n = 1, sdi = 0;
    logic [FMAX-1:0] word;
    logic [CW-1:0]   bits;
    logic            ovf, valid;
    int errs = 0, checks = 0;

    always #2.5 clk = ~clk;

    spi_frame_rx #(.FRAME_MAX(FMAX)) u0 (
        .clk(clk), .rst(rst), .spi_sck(sck), .spi_sel_n(sel_n), .spi_sdi(sdi),
        .frm_word(word), .frm_bits(bits), .frm_ovf(ovf), .frm_valid(valid));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [FMAX-1:0] exp_word(input logic [79:0] p, input int n);
        logic [79:0] r;
        if (n > FMAX) r = p >> (n - FMAX);
        else          r = p & ((80'h1 << n) - 80'h1);
        return r[FMAX-1:0];
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sck_pulse();
        cyc(2); sck = 1; cyc(4); sck = 0; cyc(2);
    endtask

    task automatic send(input logic [79:0] p, input int n);
        sel_n = 0; cyc(4);
        for (int i = 0; i < n; i++) begin
            sdi = p[n-1-i];
            sck_pulse();
        end
        cyc(2);
    endtask

    // raise select, measure strobe position/width, then check outputs
    task automatic finish_frame(input string tag, input logic [FMAX-1:0] ew,
                                input int eb, input logic eo);
        int first = -1, highs = 0;
        sel_n = 1;
        for (int k = 1; k <= 10; k++) begin
            @(negedge clk);
            if (valid) begin highs++; if (first < 0) first = k; end
        end
        chk({tag, " R1 strobe cycle"}, 128'(first), 128'(4));
        chk({tag, " R5 strobe width"}, 128'(highs), 128'(1));
        chk({tag, " R3 word"}, 128'(word), 128'(ew));
        chk({tag, " R4 bits"}, 128'(bits), 128'(eb));
        chk({tag, " R6 ovf"}, 128'(ovf), 128'(eo));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        cyc(5);
        rst = 0;
        cyc(1);
        // R9 reset state
        chk("R9 word after reset", 128'(word), 128'(0));
        chk("R9 bits after reset", 128'(bits), 128'(0));
        chk("R9 valid after reset", 128'(valid | ovf), 128'(0));

        for (int v = 0; v < NV; v++) begin
            send(VPAY[v], VLEN[v]);
            finish_frame($sformatf("vec%0d", v), exp_word(VPAY[v], VLEN[v]), VLEN[v], 1'b0);
        end

        // R6 overflow: 80 edges keep first 75
        send(80'hF0E1_D2C3_B4A5_9687_7869, 80);
        finish_frame("ovf", exp_word(80'hF0E1_D2C3_B4A5_9687_7869, 80), FMAX, 1'b1);

        // R8 short frame after long: no stale bits, ovf cleared (R6)
        send(80'h5, 3);
        finish_frame("r8_short", 75'h5, 3, 1'b0);

        // R2 bit clock pulses with select high are ignored
        begin
            int seen = 0;
            for (int i = 0; i < 3; i++) begin
                sdi = 1; cyc(2); sck = 1;
                for (int k = 0; k < 4; k++) begin @(negedge clk); if (valid) seen++; end
                sck = 0; cyc(2);
            end
            chk("R2 no strobe with select high", 128'(seen), 128'(0));
            chk("R7 bits held", 128'(bits), 128'(3));
            chk("R7 word held", 128'(word), 128'(5));
        end
        send(80'h2, 2);
        finish_frame("r2_after", 75'h2, 2, 1'b0);

        // R9 reset mid-frame, no spurious strobe afterwards
        begin
            int seen = 0;
            send(80'h1F, 5);
            rst = 1; sel_n = 1; cyc(2); rst = 0;
            for (int k = 0; k < 10; k++) begin @(negedge clk); if (valid) seen++; end
            chk("R9 no strobe after reset", 128'(seen), 128'(0));
            chk("R9 bits cleared", 128'(bits), 128'(0));
            chk("R9 word cleared", 128'(word), 128'(0));
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule